// File: doc/BRIEF.md
# Segmented Amplitude DAC Decoder with Half-Cycle Interpolation

This block turns an 8-bit amplitude word into the unit-cell enable pattern of a digital RF amplitude modulator. Each accepted word first passes through a 256-entry predistortion table. The corrected code is then split into two segments. The low four bits drive four binary-weighted enables directly. The high four bits are expanded into fifteen equal-weight thermometer enables, and each of those carries sixteen times the weight of the smallest binary cell.

Two identical enable arrays are produced. The first array registers a new pattern on the rising baseband clock edge. The second array copies that pattern on the following falling edge. When the two cell arrays are summed at the RF output, each new sample is reached in two half-cycle steps, which forms a coarse linear interpolation between consecutive samples. Software or a calibration engine loads the predistortion table through a simple write port. During a write cycle the enable outputs hold their values.

Top module: `ampdac_seg_decoder`

## Requirements
- R1: While reset is asserted, and until a word is accepted after reset, every enable of both arrays and `out_valid_o` are 0. Reset also loads the table so that entry N holds N (identity).
- R2: After a word is accepted, `rise_bin_o[i]` equals bit i of the corrected code for i = 0..3. Bit i has weight 2^i.
- R3: For a corrected code C, exactly floor(C/16) thermometer enables are set, and they fill from bit 0 upward: `rise_therm_o = 2^(C>>4) - 1`.
- R4: Code 0 sets no enables. Code 255 sets all 15 thermometer and all 4 binary enables.
- R5: A word sampled on rising edge k appears on the rising array at that edge. The falling array takes the same pattern at the next falling edge and holds the previous pattern until then.
- R6: The corrected code is the table entry at the address given by the input word. A write with `lut_we_i`=1 stores `lut_data_i` at `lut_addr_i`, and that entry is used for words accepted later.
- R7: In a cycle with `lut_we_i`=1, `in_valid_i` is ignored: no enable changes and `out_valid_o` stays 0.
- R8: With `in_valid_i`=0, both arrays hold their patterns.
- R9: `out_valid_o` is 1 for exactly the cycle after each accepted word, aligned with the rising-array update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Baseband clock; both edges are used |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Amplitude word present |
| in_amp_i | input | 8 | Amplitude word |
| lut_we_i | input | 1 | Table write strobe |
| lut_addr_i | input | 8 | Table write address |
| lut_data_i | input | 8 | Table write data |
| rise_therm_o | output | 15 | Rising-edge array thermometer enables |
| rise_bin_o | output | 4 | Rising-edge array binary enables |
| fall_therm_o | output | 15 | Falling-edge array thermometer enables |
| fall_bin_o | output | 4 | Falling-edge array binary enables |
| out_valid_o | output | 1 | Rising array updated this cycle |

## Verification
A corrupted table entry shows up only when that address is later presented. It then appears on the rising array one edge after acceptance, so every table write is followed by a read of the same address. A broken thermometer decode shows as a gap or an overcount in the enables on the first affected code. The vectors therefore cover each segment boundary (15/16, 239/240, 255). A lost or mistimed copy into the falling array shows within half a cycle, so each word is sampled both before and after the falling edge.

// File: rtl/ampdac_pkg.sv
package ampdac_pkg;
  localparam int unsigned AMP_W   = 8;
  localparam int unsigned BIN_W   = 4;
  localparam int unsigned MSB_W   = AMP_W - BIN_W;
  localparam int unsigned THERM_W = (1 << MSB_W) - 1;
  localparam int unsigned DEPTH   = 1 << AMP_W;

  typedef logic [AMP_W-1:0]   amp_t;
  typedef logic [BIN_W-1:0]   bin_t;
  typedef logic [THERM_W-1:0] therm_t;

  typedef struct packed {
    therm_t therm;
    bin_t   bin;
  } cells_t;
endpackage

// File: rtl/ampdac_lut.sv
module ampdac_lut
  import ampdac_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  amp_t waddr_i,
  input  amp_t wdata_i,
  input  amp_t raddr_i,
  output amp_t rdata_o
);
  amp_t tab_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = we_i && (waddr_i == AMP_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tab_q[e] <= AMP_W'(e);
      else if (hit) tab_q[e] <= wdata_i;
    end
  end

  assign rdata_o = tab_q[raddr_i];
endmodule

// File: rtl/ampdac_seg_split.sv
module ampdac_seg_split
  import ampdac_pkg::*;
(
  input  amp_t   code_i,
  output cells_t cells_o
);
  logic [MSB_W-1:0] upper;
  assign upper = code_i[AMP_W-1:BIN_W];
  assign cells_o.bin = code_i[BIN_W-1:0];

  for (genvar t = 0; t < THERM_W; t++) begin : g_line
    assign cells_o.therm[t] = (upper > MSB_W'(t));
  end
endmodule

// File: rtl/ampdac_edge_bank.sv
module ampdac_edge_bank
  import ampdac_pkg::*;
#(
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  cells_t d_i,
  output cells_t q_o
);
  cells_t q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (load_i) q_d = d_i;
  end

  if (FALL_EDGE) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= q_d;
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/ampdac_seg_decoder.sv
module ampdac_seg_decoder
  import ampdac_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_amp_i,
  input  logic        lut_we_i,
  input  logic [7:0]  lut_addr_i,
  input  logic [7:0]  lut_data_i,
  output logic [14:0] rise_therm_o,
  output logic [3:0]  rise_bin_o,
  output logic [14:0] fall_therm_o,
  output logic [3:0]  fall_bin_o,
  output logic        out_valid_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic   accept;
  amp_t   code;
  cells_t dec_cells, rise_cells, fall_cells;
  logic   vld_d, vld_q;

  assign accept = in_valid_i && !lut_we_i;

  ampdac_lut u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (lut_we_i),
    .waddr_i(lut_addr_i),
    .wdata_i(lut_data_i),
    .raddr_i(in_amp_i),
    .rdata_o(code)
  );

  ampdac_seg_split u_split (
    .code_i (code),
    .cells_o(dec_cells)
  );

  ampdac_edge_bank #(.FALL_EDGE(1'b0)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .load_i(accept),
    .d_i   (dec_cells),
    .q_o   (rise_cells)
  );

  ampdac_edge_bank #(.FALL_EDGE(1'b1)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .load_i(1'b1),
    .d_i   (rise_cells),
    .q_o   (fall_cells)
  );

  assign vld_d = accept;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign rise_therm_o = rise_cells.therm;
  assign rise_bin_o   = rise_cells.bin;
  assign fall_therm_o = fall_cells.therm;
  assign fall_bin_o   = fall_cells.bin;
  assign out_valid_o  = vld_q;

  // thermometer lines always fill contiguously from line 0
  p_therm_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((rise_therm_o & (rise_therm_o + 15'd1)) == 15'd0));

  // falling array mirrors rising array by every rising edge
  p_fall_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fall_therm_o == rise_therm_o) && (fall_bin_o == rise_bin_o));

  // write cycle blocks any update
  p_hold_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    lut_we_i |=> ($stable(rise_therm_o) && $stable(rise_bin_o) && !out_valid_o));

  // no word, no change
  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_valid_i |=> ($stable(rise_therm_o) && $stable(rise_bin_o)));

  // strobe follows each accepted word by one cycle
  p_valid_align_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_valid_i && !lut_we_i) |=> out_valid_o);
endmodule

// File: tb/ampdac_seg_decoder_bench.sv
`timescale 1ns/1ps
module ampdac_seg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        in_valid;
  logic [7:0]  in_amp;
  logic        lut_we;
  logic [7:0]  lut_addr;
  logic [7:0]  lut_data;
  logic [14:0] rise_therm, fall_therm;
  logic [3:0]  rise_bin, fall_bin;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  logic [7:0]  model [256];
  logic [14:0] prev_t;
  logic [3:0]  prev_b;

  always #5 clk = ~clk;

  ampdac_seg_decoder u_ampdac_seg_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_amp_i(in_amp),
    .lut_we_i(lut_we), .lut_addr_i(lut_addr), .lut_data_i(lut_data),
    .rise_therm_o(rise_therm), .rise_bin_o(rise_bin),
    .fall_therm_o(fall_therm), .fall_bin_o(fall_bin), .out_valid_o(out_valid)
  );

  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{8'd0, 8'd1, 8'd15, 8'd16, 8'd17, 8'd127,
                                      8'd128, 8'd200, 8'd239, 8'd240, 8'd254, 8'd255};

  function automatic logic [14:0] exp_therm(input logic [7:0] c);
    logic [15:0] w;
    w = (16'd1 << c[7:4]) - 16'd1;
    return w[14:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) model[i] = 8'(i);
    prev_t = '0;
    prev_b = '0;
  endtask

  task automatic send(input logic vld, input logic [7:0] amp, input logic we,
                      input logic [7:0] wa, input logic [7:0] wd, input string req);
    logic [14:0] nt;
    logic [3:0]  nb;
    logic        acc;
    @(posedge clk); #2;
    in_valid = vld; in_amp = amp; lut_we = we; lut_addr = wa; lut_data = wd;
    @(posedge clk); #2;
    in_valid = 1'b0; lut_we = 1'b0;
    acc = vld && !we;
    nt = prev_t; nb = prev_b;
    if (acc) begin
      nt = exp_therm(model[amp]);
      nb = model[amp][3:0];
    end
    if (we) model[wa] = wd;
    #1;
    check({req, " R3 rise therm"}, 32'(rise_therm), 32'(nt));
    check({req, " R2 rise bin"},   32'(rise_bin),   32'(nb));
    check({req, " R9 valid"},      32'(out_valid),  32'(acc));
    check({req, " R5 fall before"}, 32'({fall_therm, fall_bin}), 32'({prev_t, prev_b}));
    #4;
    check({req, " R5 fall after"},  32'({fall_therm, fall_bin}), 32'({nt, nb}));
    prev_t = nt; prev_b = nb;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; in_valid = 1'b0; in_amp = '0;
    lut_we = 1'b0; lut_addr = '0; lut_data = '0;
    model_reset();
    #1;
    check("R1 reset enables", 32'({rise_therm, rise_bin, fall_therm, fall_bin}), 32'd0);
    check("R1 reset valid", 32'(out_valid), 32'd0);
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    check("R1 after release", 32'({rise_therm, rise_bin, fall_therm, fall_bin, out_valid}), 32'd0);

    // identity table sweep over segment boundaries
    for (int v = 0; v < NV; v++) send(1'b1, VEC[v], 1'b0, 8'd0, 8'd0, "vec");

    // R4: extremes
    send(1'b1, 8'd255, 1'b0, 8'd0, 8'd0, "R4 full");
    check("R4 all on", 32'({rise_therm, rise_bin}), 32'h7FFFF);
    send(1'b1, 8'd0, 1'b0, 8'd0, 8'd0, "R4 zero");
    check("R4 all off", 32'({rise_therm, rise_bin}), 32'd0);

    // R6: predistortion writes then lookups
    send(1'b0, 8'd0, 1'b1, 8'd10, 8'd255, "R6 write10");
    send(1'b0, 8'd0, 1'b1, 8'd200, 8'h35, "R6 write200");
    send(1'b1, 8'd10, 1'b0, 8'd0, 8'd0, "R6 read10");
    send(1'b1, 8'd200, 1'b0, 8'd0, 8'd0, "R6 read200");
    send(1'b1, 8'd11, 1'b0, 8'd0, 8'd0, "R6 untouched11");

    // R7: valid word during a write cycle is ignored
    send(1'b1, 8'd100, 1'b1, 8'd50, 8'd77, "R7 write with valid");
    send(1'b1, 8'd50, 1'b0, 8'd0, 8'd0, "R7 read50");

    // R8: idle cycles hold
    send(1'b0, 8'd255, 1'b0, 8'd0, 8'd0, "R8 idle1");
    send(1'b0, 8'd0, 1'b0, 8'd0, 8'd0, "R8 idle2");

    // R1: mid-run reset clears outputs and restores identity table
    send(1'b1, 8'd180, 1'b0, 8'd0, 8'd0, "pre-reset");
    #1 rst_ni = 1'b0;
    #1;
    check("R1 midrun clear", 32'({rise_therm, rise_bin, fall_therm, fall_bin, out_valid}), 32'd0);
    model_reset();
    repeat (2) @(posedge clk);
    #2 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    send(1'b1, 8'd10, 1'b0, 8'd0, 8'd0, "R1 identity restored");
    send(1'b1, 8'd50, 1'b0, 8'd0, 8'd0, "R1 identity restored 50");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule